// File: doc/BRIEF.md
# Outbound Address Translation Windows

This block turns a 36-bit local request address into a 64-bit address for a serial-link bus. Four programmable windows are checked against the address, each defined by a size-aligned base, a power-of-two size from 4 KB to 64 GB, a translated upper-address field, an enable and a transaction-type flag (memory or I/O). When no window matches, a fallback default window supplies only the high link-address bits.

Translation substitutes bits. It does not add an offset. Inside a matched window, the local bits below the window size and the low 12 page-offset bits pass straight through. Every bit above the size boundary, and every link bit above the local width, comes from the window's translated field. The result is registered, so each request produces its answer on the cycle after it is presented.

Configuration uses a small register port. `cfg_sel` picks the window: 0 to 3 are the programmable windows and 4 is the default window. `cfg_field` picks the field to write.

Top module: `outbound_xlat`

## Requirements
- R1: After reset, `out_valid` is 0 and every programmable window is disabled. All translated fields are zero, so any request gives `out_win`=4, `out_io`=0 and `out_addr`={28'h0, local address}.
- R2: `out_valid` is high on exactly the cycles that follow a cycle with `req_valid` high. The other outputs show the result for that request.
- R3: `out_addr[11:0]` always equals bits [11:0] of the request address.
- R4: An enabled window w with size code s matches when the request address and the stored base agree on bits [35:s]. Base bits below s have no effect. The base is written with `cfg_field`=0, using `cfg_wdata[35:12]`.
- R5: For a matched window, `out_addr[63:s]` comes from that window's translated field and `out_addr[s-1:12]` comes from the request address. Translated-field bits below s have no effect. The translated field is written with `cfg_field`=1, using `cfg_wdata[63:12]`.
- R6: When several enabled windows match, the one with the lowest index is reported in `out_win` and used for translation.
- R7: When no enabled window matches, `out_win`=4, `out_io`=0 and `out_addr`={default translated field bits [63:36], request address}. The default field is written with `cfg_sel`=4 and `cfg_field`=1.
- R8: For a matched window, `out_io` equals that window's type flag. The attribute word is written with `cfg_field`=2: size code in `cfg_wdata[5:0]`, type flag in bit 6 (1 = I/O), enable in bit 7.
- R9: A size code below 12 acts as 12 (4 KB), and a size code above 36 acts as 36 (64 GB).
- R10: A configuration write affects requests presented on later cycles. A request presented in the same cycle as a write is translated with the old settings.
- R11: A disabled window never matches, whatever its base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Window index (0..3 programmable, 4 default) |
| cfg_field | input | 2 | Field: 0 base, 1 translated field, 2 attributes |
| cfg_wdata | input | 64 | Configuration write data |
| req_valid | input | 1 | Request valid |
| req_addr | input | 36 | Local request address |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_addr | output | 64 | Translated link address |
| out_io | output | 1 | 1 = I/O transaction, 0 = memory |
| out_win | output | 3 | Index of the window used (4 = default) |

## Verification
The assertions assume that the reset has been applied and that `req_addr` is stable whenever `req_valid` is sampled. The default-window check relies on the address of the previous cycle, so it assumes that every valid result comes from a request made in the cycle just before. The bench drives every input on the falling edge and holds it for a whole cycle. It issues each request as a single-cycle pulse, so every result maps to exactly one earlier request. Window bases are derived from size-aligned values, and each sweep probes both edges of every window. The bench also writes unaligned and out-of-range values, which the requirements say must be masked or clamped.

// File: rtl/outbound_xlat.sv
module outbound_xlat #(
  parameter int LA_W  = 36,
  parameter int BA_W  = 64,
  parameter int NWIN  = 4,
  parameter int PG_W  = 12,
  parameter int SZ_W  = 6,
  parameter int SEL_W = $clog2(NWIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [1:0]       cfg_field,
  input  logic [BA_W-1:0]  cfg_wdata,
  input  logic             req_valid,
  input  logic [LA_W-1:0]  req_addr,
  output logic             out_valid,
  output logic [BA_W-1:0]  out_addr,
  output logic             out_io,
  output logic [SEL_W-1:0] out_win
);

  logic [LA_W-1:PG_W] base_q [NWIN];
  logic [BA_W-1:PG_W] xlat_q [NWIN+1];
  logic [SZ_W-1:0]    sz_q   [NWIN];
  logic [NWIN-1:0]    io_q, en_q, hit;
  logic [BA_W-1:0]    tr     [NWIN];

  logic [BA_W-1:0]  sel_addr;
  logic [SEL_W-1:0] sel_win;
  logic             sel_io;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++) begin
        base_q[i] <= '0;
        sz_q[i]   <= SZ_W'(PG_W);
        io_q[i]   <= 1'b0;
        en_q[i]   <= 1'b0;
      end
      for (int i = 0; i <= NWIN; i++) xlat_q[i] <= '0;
    end else if (cfg_we) begin
      for (int i = 0; i < NWIN; i++) begin
        if (cfg_sel == SEL_W'(i)) begin
          case (cfg_field)
            2'd0: base_q[i] <= cfg_wdata[LA_W-1:PG_W];
            2'd2: begin
              sz_q[i] <= cfg_wdata[SZ_W-1:0];
              io_q[i] <= cfg_wdata[SZ_W];
              en_q[i] <= cfg_wdata[SZ_W+1];
            end
            default: ;
          endcase
        end
      end
      for (int i = 0; i <= NWIN; i++)
        if (cfg_sel == SEL_W'(i) && cfg_field == 2'd1)
          xlat_q[i] <= cfg_wdata[BA_W-1:PG_W];
    end
  end

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    logic [SZ_W-1:0]    sz_eff;
    logic [LA_W-1:PG_W] msk;

    assign sz_eff = (sz_q[g] < SZ_W'(PG_W)) ? SZ_W'(PG_W) :
                    (sz_q[g] > SZ_W'(LA_W)) ? SZ_W'(LA_W) : sz_q[g];

    always_comb begin
      msk = '0;
      for (int b = PG_W; b < LA_W; b++) msk[b] = (sz_eff <= SZ_W'(b));
    end

    assign hit[g] = en_q[g] && (((req_addr[LA_W-1:PG_W] ^ base_q[g]) & msk) == '0);
    assign tr[g]  = {xlat_q[g][BA_W-1:LA_W],
                     (xlat_q[g][LA_W-1:PG_W] & msk) | (req_addr[LA_W-1:PG_W] & ~msk),
                     req_addr[PG_W-1:0]};

    a_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !en_q[g]) |=> (out_win != SEL_W'(g)));
  end

  always_comb begin
    sel_win  = SEL_W'(NWIN);
    sel_io   = 1'b0;
    sel_addr = {xlat_q[NWIN][BA_W-1:LA_W], req_addr};
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit[i]) begin
        sel_win  = SEL_W'(i);
        sel_io   = io_q[i];
        sel_addr = tr[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_io    <= 1'b0;
      out_win   <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_addr <= sel_addr;
        out_io   <= sel_io;
        out_win  <= sel_win;
      end
    end
  end

  a_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  a_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);
  a_pageoff_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (out_addr[PG_W-1:0] == $past(req_addr[PG_W-1:0])));
  a_default_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_win == SEL_W'(NWIN)) |->
      (!out_io && out_addr[LA_W-1:0] == $past(req_addr)));
  a_winrange_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_win <= SEL_W'(NWIN)));

endmodule

// File: tb/sim_outbound_xlat.sv
`timescale 1ns/1ps
module sim_outbound_xlat;
  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_sel = 0;
  logic [1:0]  cfg_field = 0;
  logic [63:0] cfg_wdata = 0;
  logic        req_valid = 0;
  logic [35:0] req_addr = 0;
  logic        out_valid, out_io;
  logic [63:0] out_addr;
  logic [2:0]  out_win;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [63:0] mb [4];
  logic [63:0] mx [5];
  int          ms [4];
  bit          mi [4], me [4];
  logic [35:0] lfsr = 36'h9_1234_5678;

  outbound_xlat u0 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_addr(req_addr), .out_valid(out_valid), .out_addr(out_addr),
    .out_io(out_io), .out_win(out_win));

  always #4 clk = ~clk;

  function automatic int clampf(input int s);
    if (s < 12) return 12;
    if (s > 36) return 36;
    return s;
  endfunction

  function automatic logic [35:0] maskf(input int s);
    logic [63:0] m64;
    m64 = ~((64'd1 << clampf(s)) - 64'd1);
    return m64[35:0];
  endfunction

  function automatic void model(input logic [35:0] a, output int w,
                                output logic [63:0] ad, output bit io);
    logic [35:0] m;
    w = 4; io = 0; ad = {mx[4][63:36], a};
    for (int i = 3; i >= 0; i--) begin
      if (me[i]) begin
        m = maskf(ms[i]);
        if (((a ^ mb[i][35:0]) & m) == 36'd0) begin
          w = i; io = mi[i];
          ad = {mx[i][63:36], (mx[i][35:0] & m) | (a & ~m)};
        end
      end
    end
  endfunction

  function automatic logic [35:0] nxt();
    lfsr = {lfsr[34:0], lfsr[35] ^ lfsr[24]};
    return lfsr;
  endfunction

  task automatic wr(input int sel, input int fld, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 3'(sel); cfg_field = 2'(fld); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (sel < 4 && fld == 0) mb[sel] = d & ~64'hfff;
    if (sel <= 4 && fld == 1) mx[sel] = d & ~64'hfff;
    if (sel < 4 && fld == 2) begin ms[sel] = int'(d[5:0]); mi[sel] = d[6]; me[sel] = d[7]; end
  endtask

  task automatic cfg_win(input int w, input logic [63:0] base, input logic [63:0] x,
                         input int sz, input bit io, input bit en);
    wr(w, 0, base);
    wr(w, 1, x);
    wr(w, 2, {56'd0, en, io, 6'(sz)});
  endtask

  task automatic chk(input string rq, input logic [35:0] a, input int ew,
                     input logic [63:0] ea, input bit eio);
    checks++;
    if (out_valid !== 1'b1 || out_win !== 3'(ew) || out_addr !== ea || out_io !== eio) begin
      failures++;
      $display("FAIL %s addr=%h: got v=%b win=%0d io=%b out=%h exp win=%0d io=%b out=%h",
               rq, a, out_valid, out_win, out_io, out_addr, ew, eio, ea);
    end
  endtask

  task automatic req(input string rq, input logic [35:0] a);
    int w; logic [63:0] ea; bit io;
    model(a, w, ea, io);
    @(negedge clk);
    req_valid = 1; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk(rq, a, w, ea, io);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [35:0] b, a, m;
    int s;
    for (int i = 0; i < 4; i++) begin mb[i] = 0; ms[i] = 12; mi[i] = 0; me[i] = 0; end
    for (int i = 0; i < 5; i++) mx[i] = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin failures++; $display("FAIL R1 reset out_valid=%b exp 0", out_valid); end
    rst_n = 1;
    // R1: reset state goes through default window with zero upper bits
    req("R1", 36'h8_7654_3ABC);
    req("R1", 36'hF_FFFF_FFFF);
    // R2: idle cycle after request gives out_valid low
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin failures++; $display("FAIL R2 idle out_valid=%b exp 0", out_valid); end

    // R7: default window upper bits
    wr(4, 1, 64'hDEAD_BEEF_0000_0FFF);
    req("R7", 36'h1_2345_6789);

    // R4 R5 R3: size sweep on window 0
    for (int k = 0; k < 7; k++) begin
      case (k)
        0: s = 12; 1: s = 13; 2: s = 17; 3: s = 24; 4: s = 30; 5: s = 35; default: s = 36;
      endcase
      m = maskf(s);
      b = 36'hA_5A5A_5A5A & m;
      cfg_win(0, {28'hFFFF_FFF, b | 36'h0_0000_0A5A}, 64'hFEDC_BA98_7654_3210, s, 0, 1);
      req("R4", b);
      req("R5", b | ~m);
      req("R4", b + (~m + 36'd1));
      req("R4", b - 36'd1);
      for (int j = 0; j < 12; j++) begin
        a = nxt();
        req("R3", a);
        req("R5", (a & ~m) | b);
      end
    end

    // R8 R6: overlapping windows with type flags
    cfg_win(0, 64'h0_1000_0000, 64'h1111_0000_0000_0000, 16, 1, 1);
    cfg_win(1, 64'h0_1000_0000, 64'h2222_2222_2222_2000, 24, 0, 1);
    cfg_win(2, 64'h0_0000_0000, 64'h3333_0003_3333_3000, 32, 1, 1);
    cfg_win(3, 64'h0_0000_0000, 64'h4444_4444_4444_4000, 36, 1, 1);
    req("R6", 36'h0_1000_0123);
    req("R6", 36'h0_1080_0123);
    req("R6", 36'h0_2000_0456);
    req("R8", 36'h5_0000_0789);
    for (int j = 0; j < 32; j++) begin
      a = nxt();
      req("R6", {a[35:30], 6'd0, a[23:0]} & ((j % 2 == 0) ? 36'h0_1FFF_FFFF : 36'hF_FFFF_FFFF));
    end

    // R11: disabled windows never match
    cfg_win(3, 64'h0, 64'h0, 36, 1, 0);
    cfg_win(2, 64'h0, 64'h0, 36, 1, 0);
    req("R11", 36'h7_0000_0001);
    req("R11", 36'h0_1000_0001);

    // R9: size clamps
    cfg_win(1, 64'h0, 64'h0, 12, 0, 0);
    cfg_win(0, 64'h0_4000_0000, 64'h5555_5555_5555_5000, 3, 1, 1);
    req("R9", 36'h0_4000_0FFF);
    req("R9", 36'h0_4000_1000);
    cfg_win(0, 64'h0_4000_0000, 64'h5555_5555_5555_5000, 50, 0, 1);
    req("R9", 36'hC_3210_0FED);
    req("R9", 36'h0_0000_0000);

    // R10: write in the same cycle as a request uses the old settings
    begin
      int w; logic [63:0] ea; bit io;
      a = 36'h9_8765_4321;
      model(a, w, ea, io);
      @(negedge clk);
      req_valid = 1; req_addr = a;
      cfg_we = 1; cfg_sel = 3'd0; cfg_field = 2'd1; cfg_wdata = 64'h7777_7777_7777_7000;
      @(negedge clk);
      req_valid = 0; cfg_we = 0;
      mx[0] = 64'h7777_7777_7777_7000;
      chk("R10", a, w, ea, io);
      req("R10", a);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule